// File: doc/BRIEF.md
# GPIO Pad Bank with Grouped Interrupts

This block controls a bank of general-purpose pads. Every pad owns one configuration word that sets whether it drives its pin, whether it samples the pin, how the sampled value is inverted, and which kind of input activity raises an event. The pin input is synchronised before it is used. The block then inverts it if asked and turns it into level, rising-edge or any-edge events. Events latch into sticky status bits. Status bits are gathered in groups of 32 pads, and each group has a matching enable mask. One interrupt line is high whenever any status bit in any group is set while its enable bit is set.

Software reaches every register through a plain word-addressed write port with a combinational read port. Falling-edge and low-level sensing have no encodings of their own. They are set up as rising-edge or high-level sensing with the invert bit set, because detection always looks at the value after inversion. The pad-mode and interrupt-route fields are only stored and read back. Each pad also presents its logical value. When transmit is disabled this is the received value; otherwise it is the transmitted value.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: After reset, every configuration word reads 0x0000002C (transmit and receive disabled, event field = disabled). Every status and enable register reads 0. `irq` is 0 and every `pad_oe` is 0. Word address p (0..NUM_PADS-1) is pad p's configuration. NUM_PADS+g is group g's status register and NUM_PADS+NUM_GROUPS+g is group g's enable register. Any other address reads 0.
- R2: Configuration bit 0 is the transmit value and drives `pad_out`. Bit 2 is transmit-disable, and `pad_oe` is its inverse. Both outputs follow the word in the cycle after it is written.
- R3: Bit 3 is receive-disable. Bit 1 is read-only and reads the pad input two clock edges after the input changes when receive is enabled. It reads 0 when receive is disabled. Writes to bit 1 are ignored.
- R4: `pad_val` equals the receive-state bit when transmit is disabled, and the transmit bit otherwise. This holds for output-only, input-only and bidirectional pads.
- R5: Bits 5:4 select the event kind: 00 level, 01 rising edge, 10 disabled, 11 both edges. Detection acts on the synchronised input XOR invert bit 6, forced to 0 while receive is disabled.
- R6: In level mode (00), the status bit is set on every cycle the detected value is 1. A clear written while the level holds has no lasting effect.
- R7: In edge mode (01), a 0-to-1 change of the detected value sets the status bit. With the invert bit set, this senses falling pin edges. In both-edges mode (11), either change sets it.
- R8: A pad in event mode 10, or a pad with receive disabled, never sets its status bit.
- R9: Status bits are sticky. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R10: Bit b of group g's status and enable registers belongs to pad g*32+b. The enable register is read/write. `irq` is the OR over all groups of status AND enable.
- R11: Bits 9:7 (pad mode) and 13:10 (route enables) are stored and read back unchanged. Bits 31:14 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pad_in | input | NUM_GROUPS*GROUP_W | Raw pad input levels |
| pad_out | output | NUM_GROUPS*GROUP_W | Pad output levels |
| pad_oe | output | NUM_GROUPS*GROUP_W | Pad output enables |
| pad_val | output | NUM_GROUPS*GROUP_W | Logical value of each pad |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check three things on every cycle. A status bit only rises in the cycle after an event was detected. A bit that is not being cleared never drops. A clear with no competing event always takes effect. A further assertion requires that a pad in edge mode never reports two events in a row while its configuration stays the same. The bench's scenarios cover the rest. It sweeps every pad through every event kind, both invert settings and all four input transitions, and compares the status word and `irq` with values worked out from the mode table. Directed scenarios measure the two-edge receive latency, the write-0 and write-1 clear cases, the masking of one group against another, and the readback of stored and read-only bits.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int DATA_W = 32;
  localparam int PM_W   = 3;
  localparam int RT_W   = 4;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'b00,
    EV_EDGE  = 2'b01,
    EV_OFF   = 2'b10,
    EV_BOTH  = 2'b11
  } ev_mode_e;

  typedef struct packed {
    logic [RT_W-1:0] route;
    logic [PM_W-1:0] pmode;
    logic            inv;
    ev_mode_e        ev;
    logic            rx_dis;
    logic            tx_dis;
    logic            tx_state;
  } pad_cfg_t;

  localparam pad_cfg_t CFG_RST = '{route: '0, pmode: '0, inv: 1'b0, ev: EV_OFF,
                                   rx_dis: 1'b1, tx_dis: 1'b1, tx_state: 1'b0};

  // word layout: 0 tx value, 1 rx state (RO), 2 tx off, 3 rx off,
  // 5:4 event kind, 6 invert, 9:7 pad mode, 13:10 route enables
  function automatic pad_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
    pad_cfg_t c;
    c.tx_state = w[0];
    c.tx_dis   = w[2];
    c.rx_dis   = w[3];
    c.ev       = ev_mode_e'(w[5:4]);
    c.inv      = w[6];
    c.pmode    = w[9:7];
    c.route    = w[13:10];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] cfg_to_word(input pad_cfg_t c, input logic rxs);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[0]     = c.tx_state;
    w[1]     = rxs;
    w[2]     = c.tx_dis;
    w[3]     = c.rx_dis;
    w[5:4]   = c.ev;
    w[6]     = c.inv;
    w[9:7]   = c.pmode;
    w[13:10] = c.route;
    return w;
  endfunction

endpackage

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  pad_cfg_t          cfg_wr,
  input  logic              pad_in,
  output logic [DATA_W-1:0] cfg_word,
  output logic              evt,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              pad_val
);

  pad_cfg_t               cfg_q, cfg_d;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   rx_state, det, rise, fall;

  // next state
  always_comb begin
    cfg_d  = cfg_we ? cfg_wr : cfg_q;
    sync_d = {sync_q[SYNC_STAGES-2:0], pad_in};
    prev_d = det;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RST;
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rx_state = !cfg_q.rx_dis && sync_q[SYNC_STAGES-1];
    det      = !cfg_q.rx_dis && (sync_q[SYNC_STAGES-1] ^ cfg_q.inv);
    rise     = det && !prev_q;
    fall     = !det && prev_q;
    unique case (cfg_q.ev)
      EV_LEVEL: evt = det;
      EV_EDGE:  evt = rise;
      EV_BOTH:  evt = rise || fall;
      default:  evt = 1'b0;
    endcase
  end

  assign cfg_word = cfg_to_word(cfg_q, rx_state);
  assign pad_out  = cfg_q.tx_state;
  assign pad_oe   = !cfg_q.tx_dis;
  assign pad_val  = cfg_q.tx_dis ? rx_state : cfg_q.tx_state;

  // an edge-mode pad with unchanged configuration cannot fire twice in a row
  assert_edge_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.ev == EV_EDGE && evt && !cfg_we) |=> !evt);

endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int GROUP_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] evt,
  input  logic               sts_we,
  input  logic               ena_we,
  input  logic [GROUP_W-1:0] wdata,
  output logic [GROUP_W-1:0] sts_q,
  output logic [GROUP_W-1:0] ena_q,
  output logic               pend_any
);

  logic [GROUP_W-1:0] sts_d, ena_d, clr_mask;

  always_comb begin
    clr_mask = sts_we ? wdata : '0;
    sts_d    = (sts_q & ~clr_mask) | evt;
    ena_d    = ena_we ? wdata : ena_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ena_q <= '0;
    end else begin
      sts_q <= sts_d;
      ena_q <= ena_d;
    end
  end

  assign pend_any = |(sts_q & ena_q);

  // a status bit rises only after an event in the previous cycle
  assert_set_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we || !sts_we |=> ((sts_q & ~$past(sts_q) & ~$past(evt)) == '0));

  // bits not being cleared never drop
  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_we |=> (($past(sts_q) & ~sts_q) == '0));

  // a clear with no competing event takes effect
  assert_clear_effective_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((sts_q & $past(clr_mask & ~evt)) == '0));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_GROUPS  = 2,
  parameter int GROUP_W     = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_GROUPS*GROUP_W-1:0] pad_in,
  output logic [NUM_GROUPS*GROUP_W-1:0] pad_out,
  output logic [NUM_GROUPS*GROUP_W-1:0] pad_oe,
  output logic [NUM_GROUPS*GROUP_W-1:0] pad_val,
  output logic                          irq
);

  localparam int NUM_PADS = NUM_GROUPS * GROUP_W;
  localparam int STS_BASE = NUM_PADS;
  localparam int ENA_BASE = NUM_PADS + NUM_GROUPS;

  logic [DATA_W-1:0]  cfg_word [NUM_PADS];
  logic [NUM_PADS-1:0] evt_all;
  logic [GROUP_W-1:0] sts_g [NUM_GROUPS];
  logic [GROUP_W-1:0] ena_g [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] pend_g;
  pad_cfg_t           cfg_wr;

  assign cfg_wr = cfg_from_word(bus_wdata);

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam logic [ADDR_W-1:0] PADDR = ADDR_W'(p);
    gpio_pad_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (bus_we && (bus_addr == PADDR)),
      .cfg_wr   (cfg_wr),
      .pad_in   (pad_in[p]),
      .cfg_word (cfg_word[p]),
      .evt      (evt_all[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .pad_val  (pad_val[p])
    );
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(STS_BASE + g);
    localparam logic [ADDR_W-1:0] EADDR = ADDR_W'(ENA_BASE + g);
    gpio_irq_group #(.GROUP_W(GROUP_W)) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_all[g*GROUP_W +: GROUP_W]),
      .sts_we   (bus_we && (bus_addr == SADDR)),
      .ena_we   (bus_we && (bus_addr == EADDR)),
      .wdata    (bus_wdata[GROUP_W-1:0]),
      .sts_q    (sts_g[g]),
      .ena_q    (ena_g[g]),
      .pend_any (pend_g[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PADS; i++)
      if (bus_addr == ADDR_W'(i)) bus_rdata = cfg_word[i];
    for (int i = 0; i < NUM_GROUPS; i++) begin
      if (bus_addr == ADDR_W'(STS_BASE + i)) bus_rdata = DATA_W'(sts_g[i]);
      if (bus_addr == ADDR_W'(ENA_BASE + i)) bus_rdata = DATA_W'(ena_g[i]);
    end
  end

  assign irq = |pend_g;

endmodule

// File: tb/gpio_pad_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_tb;

  localparam int NG = 2;
  localparam int GW = 32;
  localparam int NP = NG * GW;
  localparam int STS = NP;
  localparam int ENA = NP + NG;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_we;
  logic [7:0]    bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in, pad_out, pad_oe, pad_val;
  logic          irq;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  gpio_pad_ctrl #(.NUM_GROUPS(NG), .GROUP_W(GW), .ADDR_W(8), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_val(pad_val), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic        eo, en, ex;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state and address map
    for (int a = 0; a < NP + 2 * NG + 2; a++) begin
      rd(a, d);
      chk("R1 reset readback", d, (a < NP) ? 32'h2C : 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 pad_oe low", 32'(pad_oe != '0), 32'd0);

    // R2/R4: output-only pad
    pad_in[7] = 1'b1;
    wr(7, 32'h29);
    chk("R2 pad_out", {31'd0, pad_out[7]}, 32'd1);
    chk("R2 pad_oe", {31'd0, pad_oe[7]}, 32'd1);
    chk("R4 val out-only", {31'd0, pad_val[7]}, 32'd1);
    wr(7, 32'h28);
    chk("R2 pad_out low", {31'd0, pad_out[7]}, 32'd0);
    chk("R4 val ignores input", {31'd0, pad_val[7]}, 32'd0);
    // R4: bidirectional pad reports transmit value
    pad_in[7] = 1'b0;
    wr(7, 32'h21);
    idle(3);
    chk("R4 val bidir", {31'd0, pad_val[7]}, 32'd1);
    rd(7, d);
    chk("R3 bidir readback", d, 32'h21);
    wr(7, 32'h2C);

    // R3: two-edge receive latency, input-only pad (R4)
    wr(40, 32'h24);
    idle(2);
    pad_in[40] = 1'b1;
    @(posedge clk); #1;
    rd(40, d);
    chk("R3 rx after one edge", {31'd0, d[1]}, 32'd0);
    @(posedge clk); #1;
    rd(40, d);
    chk("R3 rx after two edges", {31'd0, d[1]}, 32'd1);
    chk("R4 val in-only", {31'd0, pad_val[40]}, 32'd1);
    @(negedge clk);
    wr(40, 32'h2C);
    rd(40, d);
    chk("R3 rx disabled reads 0", d, 32'h2C);
    chk("R4 val rx disabled", {31'd0, pad_val[40]}, 32'd0);
    pad_in[40] = 1'b0;

    // R11: stored fields and read-only bit
    pad_in[9] = 1'b1;
    wr(9, 32'hFFFF_FFFF);
    rd(9, d);
    chk("R11 stored bits", d, 32'h0000_3FFD);
    wr(9, 32'hFFFF_FFF5);
    idle(3);
    rd(9, d);
    chk("R11 rx bit read-only", d, 32'h0000_3FF7);
    wr(9, 32'h2C);
    pad_in[9] = 1'b0;
    idle(3);
    wr(STS, 32'hFFFF_FFFF);
    rd(STS, d);
    chk("R9 clear all", d, 32'd0);

    // R5-R8, R10: every pad, mode, invert setting and transition
    for (int p = 0; p < NP; p++) begin
      wr(ENA + p / GW, 32'd1 << (p % GW));
      for (int m = 0; m < 4; m++)
        for (int v = 0; v < 2; v++)
          for (int t = 0; t < 4; t++) begin
            pad_in[p] = t[1];
            wr(p, 32'h4 | (32'(m) << 4) | (32'(v) << 6));
            idle(4);
            wr(STS + p / GW, 32'd1 << (p % GW));
            pad_in[p] = t[0];
            idle(4);
            eo = t[1] ^ v[0];
            en = t[0] ^ v[0];
            case (m)
              0: ex = eo | en;       // R6 level, clear loses while held
              1: ex = !eo & en;      // R7 rising of detected value
              3: ex = eo ^ en;       // R7 both edges
              default: ex = 1'b0;    // R8 disabled mode
            endcase
            rd(STS + p / GW, d);
            chk("R5 status after transition", d, 32'(ex) << (p % GW));
            chk("R10 irq follows enabled bit", {31'd0, irq}, {31'd0, ex});
          end
      wr(p, 32'h2C);
      pad_in[p] = 1'b0;
      wr(STS + p / GW, 32'hFFFF_FFFF);
      wr(ENA + p / GW, 32'h0);
    end

    // R8: receive disabled suppresses events
    wr(12, 32'h3C);
    pad_in[12] = 1'b1; idle(4);
    pad_in[12] = 1'b0; idle(4);
    rd(STS, d);
    chk("R8 rx disabled no event", d, 32'd0);
    wr(12, 32'h2C);

    // R9: write 0 keeps, write 1 clears
    wr(5, 32'h14);
    pad_in[5] = 1'b1; idle(4);
    wr(STS, 32'h0);
    rd(STS, d);
    chk("R9 write 0 no effect", d, 32'h20);
    wr(STS, 32'h20);
    rd(STS, d);
    chk("R9 write 1 clears", d, 32'h0);

    // R10: group masking, pad 33 is group 1 bit 1
    wr(33, 32'h14);
    pad_in[33] = 1'b1; idle(4);
    rd(STS + 1, d);
    chk("R10 group1 bit1", d, 32'h2);
    wr(ENA, 32'hFFFF_FFFF);
    wr(ENA + 1, 32'hFFFF_FFFD);
    chk("R10 masked irq", {31'd0, irq}, 32'd0);
    rd(ENA + 1, d);
    chk("R10 enable readback", d, 32'hFFFF_FFFD);
    wr(ENA + 1, 32'h2);
    chk("R10 unmasked irq", {31'd0, irq}, 32'd1);

    summary();
  end

endmodule